// File: doc/BRIEF.md
# Conditional Branch Target Unit

This unit resolves one branch-class instruction per clock. It checks the instruction's 4-bit condition code against the four arithmetic flags: negative, zero, carry and overflow. It then picks the address the fetch stage should go to next. That address is one of three things:

- a target relative to the program counter, built from a signed 24-bit word offset;
- an absolute target taken from a register write to the program counter;
- the sequential address, when the branch is not taken.

A call-type branch that is taken also produces a return address and a write strobe for the link register.

The unit is meant to sit in the execute stage of a small 32-bit core. The decoder supplies the instruction address, the branch kind, the condition code, the offset and the absolute target. The flag register supplies the current flags. All four results leave through registers, so they are valid in the cycle after the inputs are sampled. Switching between instruction sets and flushing the pipeline are handled by other logic.

Top module: `bru_branch_unit`

## Requirements
- R1: Condition codes are evaluated as follows, with N, Z, C, V the flag inputs. 0: Z. 1: not Z. 2: C. 3: not C. 4: N. 5: not N. 6: V. 7: not V. 8: C and not Z. 9: not C or Z. 10: N equals V. 11: N differs from V. 12: not Z and N equals V. 13: Z or N differs from V. 14: always true.
- R2: For kind 0 (relative) and kind 1 (relative with link), a true condition gives a target of instruction address + 8 + (sign-extended offset × 4).
- R3: The relative reach runs from -33554432 bytes (offset 0x800000) to +33554428 bytes (offset 0x7FFFFF), both measured from instruction address + 8. The target wraps modulo 2^32.
- R4: When the condition is false, taken is 0, the next address is instruction address + 4, and the link write strobe is 0.
- R5: The link write strobe is 1 only for kind 1 with a true condition.
- R6: When the link write strobe is 1, the link value equals instruction address + 4.
- R7: For kind 2 (write to the program counter) with a true condition, the next address is the absolute target input, unchanged and unaligned.
- R8: Kind 3 is not a branch. Taken is 0, the next address is instruction address + 4 and no link write occurs, whatever the condition.
- R9: Condition code 15 never passes. Taken is 0 for every flag value.
- R10: While rst is high at a rising edge, taken, link write strobe, next address and link value all become 0.
- R11: The outputs are registered. They reflect the inputs sampled at the previous rising edge and stay stable between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_kind | input | 2 | 0 relative, 1 relative with link, 2 absolute program-counter write, 3 not a branch |
| cond_code | input | 4 | Condition code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| insn_pc | input | 32 | Address of the branch instruction |
| br_offset | input | 24 | Signed word offset |
| reg_target | input | 32 | Absolute target for a program-counter write |
| taken_q | output | 1 | Branch taken, registered |
| next_pc_q | output | 32 | Next fetch address, registered |
| link_addr_q | output | 32 | Return address, registered |
| link_we_q | output | 1 | Link register write strobe, registered |

## Verification
Every condition code is driven with one flag pattern that makes it pass and, where it can be told apart, one that makes it fail. This separates the even codes from their odd complements and the compound tests from the single-flag tests. The offset is tried at zero, at -1, at small positive values and at both extremes. These cases distinguish the correct sign extension, the scaling by four and the +8 base from off-by-one alternatives. The call, absolute and non-branch kinds are each run with passing and failing conditions, so a wrong link strobe or a wrong target source shows up on the ports. Directed steps then check the reset values, the one-cycle latency and that outputs hold between edges.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    BK_REL  = 2'd0,
    BK_LINK = 2'd1,
    BK_ABS  = 2'd2,
    BK_NONE = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic [COND_W-1:0] cond,
  input  flags_t            flags,
  output logic              pass
);
  localparam int PAIRS = 1 << (COND_W - 1);

  // Each even code has a base test; the odd code next to it is the inverse.
  logic [PAIRS-1:0] base;

  generate
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
      always_comb begin
        unique case (g)
          0:       base[g] = flags.z;
          1:       base[g] = flags.c;
          2:       base[g] = flags.n;
          3:       base[g] = flags.v;
          4:       base[g] = flags.c & ~flags.z;
          5:       base[g] = ~(flags.n ^ flags.v);
          6:       base[g] = ~flags.z & ~(flags.n ^ flags.v);
          default: base[g] = 1'b1;
        endcase
      end
    end
  endgenerate

  assign pass = base[cond[COND_W-1:1]] ^ cond[0];
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 24,
  parameter int SHIFT    = 2,
  parameter int PC_AHEAD = 8,
  parameter int STEP     = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  rel_target,
  output logic [XLEN-1:0]  seq_addr
);
  localparam int EXT_W = XLEN - OFF_W - SHIFT;
  localparam logic [XLEN-1:0] AHEAD_V = XLEN'(PC_AHEAD);
  localparam logic [XLEN-1:0] STEP_V  = XLEN'(STEP);

  logic [XLEN-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
    end else begin : g_trunc
      assign disp = XLEN'({offset, {SHIFT{1'b0}}});
    end
  endgenerate

  assign rel_target = pc + AHEAD_V + disp;
  assign seq_addr   = pc + STEP_V;
endmodule

// File: rtl/bru_branch_unit.sv
module bru_branch_unit
  import bru_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 24,
  parameter int COND_W   = 4,
  parameter int SHIFT    = 2,
  parameter int PC_AHEAD = 8,
  parameter int STEP     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        br_kind,
  input  logic [COND_W-1:0] cond_code,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic [XLEN-1:0]   insn_pc,
  input  logic [OFF_W-1:0]  br_offset,
  input  logic [XLEN-1:0]   reg_target,
  output logic              taken_q,
  output logic [XLEN-1:0]   next_pc_q,
  output logic [XLEN-1:0]   link_addr_q,
  output logic              link_we_q
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  br_kind_e        kind;
  flags_t          flags;
  logic            cond_ok;
  logic [XLEN-1:0] rel_target;
  logic [XLEN-1:0] seq_addr;
  logic            taken_d;
  logic            link_d;
  logic [XLEN-1:0] next_d;

  assign kind  = br_kind_e'(br_kind);
  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  bru_cond_eval #(.COND_W(COND_W)) u_cond (
    .cond  (cond_code),
    .flags (flags),
    .pass  (cond_ok)
  );

  bru_target_calc #(
    .XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(SHIFT),
    .PC_AHEAD(PC_AHEAD), .STEP(STEP)
  ) u_tgt (
    .pc         (insn_pc),
    .offset     (br_offset),
    .rel_target (rel_target),
    .seq_addr   (seq_addr)
  );

  always_comb begin
    taken_d = cond_ok && (kind != BK_NONE);
    link_d  = cond_ok && (kind == BK_LINK);
    next_d  = seq_addr;
    if (taken_d) begin
      next_d = (kind == BK_ABS) ? reg_target : rel_target;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q     <= 1'b0;
      link_we_q   <= 1'b0;
      next_pc_q   <= '0;
      link_addr_q <= '0;
    end else begin
      taken_q     <= taken_d;
      link_we_q   <= link_d;
      next_pc_q   <= next_d;
      link_addr_q <= seq_addr;
    end
  end

  // Set once outputs hold a value loaded from real inputs.
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!taken_q && !link_we_q && next_pc_q == '0));

  a_r5_link_implies_taken: assert property (@(posedge clk) disable iff (rst)
    (primed && link_we_q) |-> taken_q);

  a_r4_fallthrough_addr: assert property (@(posedge clk) disable iff (rst)
    (primed && !taken_q) |-> (next_pc_q == $past(insn_pc) + STEP_V));

  a_r6_link_value: assert property (@(posedge clk) disable iff (rst)
    (primed && link_we_q) |-> (link_addr_q == $past(insn_pc) + STEP_V));

  a_r9_never_code: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(cond_code) == {COND_W{1'b1}}) |-> !taken_q);

  a_r8_nonbranch_idle: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(br_kind) == 2'd3) |-> (!taken_q && !link_we_q));

  a_r2_rel_alignment: assert property (@(posedge clk) disable iff (rst)
    (primed && taken_q && $past(br_kind) != 2'd2)
      |-> (next_pc_q[SHIFT-1:0] == $past(insn_pc[SHIFT-1:0])));
endmodule

// File: tb/test_bru_branch_unit.sv
`timescale 1ns/1ps
module test_bru_branch_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  br_kind;
  logic [3:0]  cond_code;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [31:0] insn_pc;
  logic [23:0] br_offset;
  logic [31:0] reg_target;
  logic        taken_q;
  logic [31:0] next_pc_q;
  logic [31:0] link_addr_q;
  logic        link_we_q;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bru_branch_unit i_bru_branch_unit (
    .clk(clk), .rst(rst), .br_kind(br_kind), .cond_code(cond_code),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .insn_pc(insn_pc), .br_offset(br_offset), .reg_target(reg_target),
    .taken_q(taken_q), .next_pc_q(next_pc_q), .link_addr_q(link_addr_q),
    .link_we_q(link_we_q)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  cond;
    logic [3:0]  nzcv;
    logic [31:0] pc;
    logic [23:0] off;
    logic [31:0] abst;
    logic        e_tk;
    logic        e_lw;
    logic [31:0] e_next;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd14, 4'b0000, 32'h1000, 24'h000010, 32'h0, 1'b1, 1'b0, 32'h1048},
    '{2'd0, 4'd0,  4'b0100, 32'h1000, 24'h000001, 32'h0, 1'b1, 1'b0, 32'h100C},
    '{2'd0, 4'd0,  4'b0000, 32'h1000, 24'h000001, 32'h0, 1'b0, 1'b0, 32'h1004},
    '{2'd0, 4'd1,  4'b0000, 32'h1000, 24'hFFFFFF, 32'h0, 1'b1, 1'b0, 32'h1004},
    '{2'd0, 4'd2,  4'b0010, 32'h1000, 24'h000002, 32'h0, 1'b1, 1'b0, 32'h1010},
    '{2'd0, 4'd3,  4'b0010, 32'h1000, 24'h000002, 32'h0, 1'b0, 1'b0, 32'h1004},
    '{2'd0, 4'd4,  4'b1000, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd5,  4'b1000, 32'h1000, 24'h000000, 32'h0, 1'b0, 1'b0, 32'h1004},
    '{2'd0, 4'd6,  4'b0001, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd7,  4'b0000, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd8,  4'b0110, 32'h1000, 24'h000000, 32'h0, 1'b0, 1'b0, 32'h1004},
    '{2'd0, 4'd8,  4'b0010, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd9,  4'b0000, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd10, 4'b1001, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd11, 4'b1000, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd12, 4'b0100, 32'h1000, 24'h000000, 32'h0, 1'b0, 1'b0, 32'h1004},
    '{2'd0, 4'd13, 4'b0100, 32'h1000, 24'h000000, 32'h0, 1'b1, 1'b0, 32'h1008},
    '{2'd0, 4'd15, 4'b0000, 32'h1000, 24'h000000, 32'h0, 1'b0, 1'b0, 32'h1004},
    '{2'd1, 4'd14, 4'b0000, 32'h2000, 24'h000004, 32'h0, 1'b1, 1'b1, 32'h2018},
    '{2'd1, 4'd0,  4'b0000, 32'h2000, 24'h000004, 32'h0, 1'b0, 1'b0, 32'h2004},
    '{2'd2, 4'd14, 4'b0000, 32'h3000, 24'h000000, 32'h12345679, 1'b1, 1'b0, 32'h12345679},
    '{2'd2, 4'd1,  4'b0100, 32'h3000, 24'h000000, 32'h12345679, 1'b0, 1'b0, 32'h3004},
    '{2'd3, 4'd14, 4'b0000, 32'h3000, 24'h000010, 32'h55555555, 1'b0, 1'b0, 32'h3004},
    '{2'd0, 4'd14, 4'b0000, 32'h04000000, 24'h800000, 32'h0, 1'b1, 1'b0, 32'h02000008},
    '{2'd0, 4'd14, 4'b0000, 32'h04000000, 24'h7FFFFF, 32'h0, 1'b1, 1'b0, 32'h06000004}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    br_kind    = v.kind;
    cond_code  = v.cond;
    {flag_n, flag_z, flag_c, flag_v} = v.nzcv;
    insn_pc    = v.pc;
    br_offset  = v.off;
    reg_target = v.abst;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 taken", {31'b0, taken_q}, 32'd0);
    check("R10 link_we", {31'b0, link_we_q}, 32'd0);
    check("R10 next_pc", next_pc_q, 32'd0);
    check("R10 link_addr", link_addr_q, 32'd0);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R1/R4/R8/R9 taken v%0d", i), {31'b0, taken_q}, {31'b0, VECS[i].e_tk});
      check($sformatf("R2/R3/R7 next_pc v%0d", i), next_pc_q, VECS[i].e_next);
      check($sformatf("R5 link_we v%0d", i), {31'b0, link_we_q}, {31'b0, VECS[i].e_lw});
      if (VECS[i].e_lw)
        check($sformatf("R6 link_addr v%0d", i), link_addr_q, VECS[i].pc + 32'd4);
    end

    // R11: new inputs do not show before the edge, do show after it
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[18]);
    #2;
    check("R11 hold before edge", next_pc_q, 32'h1048);
    check("R11 hold link_we", {31'b0, link_we_q}, 32'd0);
    @(negedge clk);
    check("R11 update after edge", next_pc_q, 32'h2018);
    check("R11 link_we after edge", {31'b0, link_we_q}, 32'd1);

    // R8: non-branch kind ignores a passing code and an offset
    drive(VECS[22]);
    cond_code = 4'd0;
    flag_z = 1'b1;
    @(negedge clk);
    check("R8 no-branch taken", {31'b0, taken_q}, 32'd0);
    check("R8 no-branch next", next_pc_q, 32'h3004);

    // R9: never-code across all flag patterns
    for (int f = 0; f < 16; f++) begin
      drive(VECS[17]);
      {flag_n, flag_z, flag_c, flag_v} = 4'(f);
      @(negedge clk);
      check($sformatf("R9 never flags=%0d", f), {31'b0, taken_q}, 32'd0);
    end

    // R10: reset mid-run clears taken outputs
    drive(VECS[18]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run taken", {31'b0, taken_q}, 32'd0);
    check("R10 mid-run link_we", {31'b0, link_we_q}, 32'd0);
    check("R10 mid-run next", next_pc_q, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule